// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It holds two component predictors. The first is a table of 2-bit saturating counters indexed only by branch address. The second is a table of 2-bit counters indexed by branch address together with a short register of the most recent resolved outcomes. A third table holds one 2-bit chooser per address, and it decides which component's guess becomes the final answer.

A fetch stage presents an address on the lookup side. In the same cycle it receives the taken/not-taken guess and a flag naming the component that was used. When a branch resolves, the execute stage presents its address and outcome on the training side with a valid strobe. On that clock edge the block trains both components and, when the components disagreed, the chooser. It then shifts the outcome into the history register.

Table sizes are parameters. The full-size build uses 13 address index bits for the address table and the chooser, 11 bits of row index for the history table, and 2 history bits. The default build uses smaller tables.

Top module: `tournament_predictor`

## Requirements
- R1: After reset, every address predicts not taken (`pred_taken`=0) using the history component (`pred_use_bim`=0), and the history register holds 00.
- R2: A counter in state 10 or 11 (MSB set) means taken; a counter in state 00 or 01 means not taken.
- R3: A chooser in state 10 or 11 selects the address-only component (`pred_use_bim`=1); a chooser in state 00 or 01 selects the history component (`pred_use_bim`=0).
- R4: On a valid update, the addressed counter in each component steps up by one on taken and down by one on not taken. Counters saturate at 11 and at 00.
- R5: The chooser changes only when the two components predicted differently for the update address. It steps one state toward 11 when the address-only component was right, and one state toward 00 when the history component was right, saturating at both ends.
- R6: The history component reads counter {row, history}, where history is the current 2-bit value. On a valid update, the training writes use the old history. Afterwards the history becomes {old history bit 0, outcome}, with the newest outcome in bit 0 (1 = taken).
- R7: Indices come from the address bits just above the ALIGN_W alignment bits: the low BIM_IDX_W of them index the address table and the chooser, and the low COR_ROW_W of them select the history-table row. Addresses that differ only in the alignment bits or above the index bits share entries. Addresses with different index bits do not.
- R8: While `upd_valid` is low, no counter, chooser or history bit changes, whatever `upd_pc` and `upd_taken` carry.
- R9: The prediction is combinational. A change of `pred_pc` changes `pred_taken` and `pred_use_bim` within the same cycle, and a training write is visible on the lookup side from the clock edge that performs it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pred_pc | input | PC_W | Branch address to predict |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_use_bim | output | 1 | 1 = address-only component chosen, 0 = history component chosen |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
The checker verifies on every cycle the properties visible on every update:
- the address-table counter and the chooser step in the required direction and saturate;
- the chooser holds whenever the components agreed;
- the history shifts in the outcome;
- nothing on the lookup side moves while no update is presented and the address is steady;
- the weak not-taken state appears right after reset.

Only the bench's scenarios can show three things. First, the history register really selects different counters within a row. Second, aliasing and non-aliasing follow the index bits. Third, a long run of identical outcomes ends in a saturated state that one contrary outcome does not flip.

// File: rtl/tp_pkg.sv
package tp_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_INIT = 2'b01;

  function automatic ctr_t ctr_step(ctr_t c, logic up);
    ctr_t r;
    if (up) r = (c == 2'b11) ? c : c + 2'd1;
    else    r = (c == 2'b00) ? c : c - 2'd1;
    return r;
  endfunction
endpackage

// File: rtl/tp_ctr_table.sv
module tp_ctr_table
  import tp_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx_a,
  output ctr_t             rd_ctr_a,
  input  logic [IDX_W-1:0] rd_idx_b,
  output ctr_t             rd_ctr_b,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_up
);
  localparam int DEPTH = 1 << IDX_W;

  ctr_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= CTR_INIT;
    end else if (wr_en) begin
      mem[wr_idx] <= ctr_step(mem[wr_idx], wr_up);
    end
  end

  assign rd_ctr_a = mem[rd_idx_a];
  assign rd_ctr_b = mem[rd_idx_b];
endmodule

// File: rtl/tp_ghist.sv
module tp_ghist #(
  parameter int HIST_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [HIST_W-1:0] hist
);
  generate
    if (HIST_W == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst)           hist <= '0;
        else if (shift_en) hist <= bit_in;
      end
    end else begin : g_shift
      always_ff @(posedge clk) begin
        if (rst)           hist <= '0;
        else if (shift_en) hist <= {hist[HIST_W-2:0], bit_in};
      end
    end
  endgenerate
endmodule

// File: rtl/tournament_predictor.sv
module tournament_predictor
  import tp_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int ALIGN_W   = 2,
  parameter int BIM_IDX_W = 10,
  parameter int COR_ROW_W = 8,
  parameter int HIST_W    = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] pred_pc,
  output logic            pred_taken,
  output logic            pred_use_bim,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken
);
  localparam int COR_IDX_W = COR_ROW_W + HIST_W;
  localparam int TOP_LSB   = ALIGN_W + BIM_IDX_W;

  logic [HIST_W-1:0]    ghist;
  logic [BIM_IDX_W-1:0] p_bim_idx, u_bim_idx;
  logic [COR_IDX_W-1:0] p_cor_idx, u_cor_idx;
  ctr_t p_bim, p_cor, p_sel;
  ctr_t u_bim, u_cor, u_sel;
  logic u_disagree, u_bim_right;

  // Index extraction above the alignment bits
  assign p_bim_idx = pred_pc[ALIGN_W +: BIM_IDX_W];
  assign u_bim_idx = upd_pc[ALIGN_W +: BIM_IDX_W];
  assign p_cor_idx = {pred_pc[ALIGN_W +: COR_ROW_W], ghist};
  assign u_cor_idx = {upd_pc[ALIGN_W +: COR_ROW_W], ghist};

  logic unused_pc_bits;
  assign unused_pc_bits = ^{pred_pc[ALIGN_W-1:0], pred_pc[PC_W-1:TOP_LSB],
                            upd_pc[ALIGN_W-1:0], upd_pc[PC_W-1:TOP_LSB]};

  tp_ctr_table #(.IDX_W(BIM_IDX_W)) u_bim_tab (
    .clk(clk), .rst(rst),
    .rd_idx_a(p_bim_idx), .rd_ctr_a(p_bim),
    .rd_idx_b(u_bim_idx), .rd_ctr_b(u_bim),
    .wr_en(upd_valid), .wr_idx(u_bim_idx), .wr_up(upd_taken)
  );

  tp_ctr_table #(.IDX_W(COR_IDX_W)) u_cor_tab (
    .clk(clk), .rst(rst),
    .rd_idx_a(p_cor_idx), .rd_ctr_a(p_cor),
    .rd_idx_b(u_cor_idx), .rd_ctr_b(u_cor),
    .wr_en(upd_valid), .wr_idx(u_cor_idx), .wr_up(upd_taken)
  );

  // Chooser trains only on disagreement, toward the component that was right
  assign u_disagree  = u_bim[1] ^ u_cor[1];
  assign u_bim_right = (u_bim[1] == upd_taken);

  tp_ctr_table #(.IDX_W(BIM_IDX_W)) u_sel_tab (
    .clk(clk), .rst(rst),
    .rd_idx_a(p_bim_idx), .rd_ctr_a(p_sel),
    .rd_idx_b(u_bim_idx), .rd_ctr_b(u_sel),
    .wr_en(upd_valid && u_disagree), .wr_idx(u_bim_idx), .wr_up(u_bim_right)
  );

  tp_ghist #(.HIST_W(HIST_W)) u_hist (
    .clk(clk), .rst(rst),
    .shift_en(upd_valid), .bit_in(upd_taken), .hist(ghist)
  );

  assign pred_use_bim = p_sel[1];
  assign pred_taken   = p_sel[1] ? p_bim[1] : p_cor[1];
endmodule

// File: rtl/tp_checker.sv
module tp_checker #(
  parameter int PC_W   = 32,
  parameter int HIST_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [PC_W-1:0]   pred_pc,
  input logic              pred_taken,
  input logic              pred_use_bim,
  input logic              upd_valid,
  input logic [PC_W-1:0]   upd_pc,
  input logic              upd_taken,
  input logic [HIST_W-1:0] hist,
  input logic [1:0]        upd_bim,
  input logic [1:0]        upd_cor,
  input logic [1:0]        upd_sel
);
  logic disagree, bim_right;
  assign disagree  = upd_bim[1] ^ upd_cor[1];
  assign bim_right = (upd_bim[1] == upd_taken);

  AST_RESET_WEAK_NT: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!pred_taken && !pred_use_bim && hist == '0)); // R1

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(upd_valid) && $stable(pred_pc))
      |-> ($stable(pred_taken) && $stable(pred_use_bim) && $stable(hist))); // R8

  AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(upd_valid))
      |-> (hist[0] == $past(upd_taken) && hist[HIST_W-1] == $past(hist[HIST_W-2]))); // R6

  AST_BIM_STEP: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(upd_valid) && upd_pc == $past(upd_pc))
      |-> (upd_bim == ($past(upd_taken)
             ? (($past(upd_bim) == 2'b11) ? 2'b11 : $past(upd_bim) + 2'd1)
             : (($past(upd_bim) == 2'b00) ? 2'b00 : $past(upd_bim) - 2'd1)))); // R4

  AST_SEL_AGREE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(upd_valid) && !$past(disagree) && upd_pc == $past(upd_pc))
      |-> (upd_sel == $past(upd_sel))); // R5

  AST_SEL_STEP: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(upd_valid) && $past(disagree) && upd_pc == $past(upd_pc))
      |-> (upd_sel == ($past(bim_right)
             ? (($past(upd_sel) == 2'b11) ? 2'b11 : $past(upd_sel) + 2'd1)
             : (($past(upd_sel) == 2'b00) ? 2'b00 : $past(upd_sel) - 2'd1)))); // R5
endmodule

bind tournament_predictor tp_checker #(.PC_W(PC_W), .HIST_W(HIST_W)) u_chk (
  .clk(clk), .rst(rst), .pred_pc(pred_pc), .pred_taken(pred_taken),
  .pred_use_bim(pred_use_bim), .upd_valid(upd_valid), .upd_pc(upd_pc),
  .upd_taken(upd_taken), .hist(ghist), .upd_bim(u_bim), .upd_cor(u_cor),
  .upd_sel(u_sel)
);

// File: tb/tb_tournament_predictor.sv
module tb_tournament_predictor;
  localparam int PC_W = 32;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [PC_W-1:0] pred_pc = '0;
  logic            pred_taken, pred_use_bim;
  logic            upd_valid = 1'b0;
  logic [PC_W-1:0] upd_pc = '0;
  logic            upd_taken = 1'b0;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  tournament_predictor dut (
    .clk(clk), .rst(rst), .pred_pc(pred_pc), .pred_taken(pred_taken),
    .pred_use_bim(pred_use_bim), .upd_valid(upd_valid), .upd_pc(upd_pc),
    .upd_taken(upd_taken)
  );

  always #5 clk = ~clk;

  task automatic chk(string req, logic exp_t, logic exp_b);
    n_tests++;
    if (pred_taken !== exp_t || pred_use_bim !== exp_b) begin
      n_fail++;
      $display("FAIL %s pc=%h taken/use_bim actual=%b%b expected=%b%b",
               req, pred_pc, pred_taken, pred_use_bim, exp_t, exp_b);
    end
  endtask

  task automatic predict(logic [PC_W-1:0] pc, logic exp_t, logic exp_b, string req);
    @(negedge clk);
    pred_pc = pc;
    #1;
    chk(req, exp_t, exp_b);
  endtask

  task automatic train(logic [PC_W-1:0] pc, logic t);
    @(negedge clk);
    upd_pc    = pc;
    upd_taken = t;
    upd_valid = 1'b1;
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    upd_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    predict(32'h0000_0000, 1'b0, 1'b0, "R1");
    predict(32'h0000_0200, 1'b0, 1'b0, "R1");
    predict(32'hFFFF_FFFC, 1'b0, 1'b0, "R1");
  endtask

  // Saturation at both ends and chooser movement
  task automatic t_saturate();
    do_reset();
    repeat (5) train(32'h200, 1'b1);
    predict(32'h200, 1'b1, 1'b1, "R4");  // counter held at 11
    train(32'h200, 1'b0);
    predict(32'h200, 1'b1, 1'b1, "R2");  // 10 still taken
    train(32'h200, 1'b0);
    predict(32'h200, 1'b0, 1'b1, "R2");  // 01 not taken
    train(32'h200, 1'b0);
    predict(32'h200, 1'b0, 1'b1, "R5");  // chooser back to 11
    train(32'h200, 1'b0);
    train(32'h200, 1'b1);
    predict(32'h200, 1'b0, 1'b1, "R4");  // 00 floor held, one taken gives 01
  endtask

  // History selects a counter within a row
  task automatic t_history();
    do_reset();
    train(32'h100, 1'b1);                // hist 00 -> 01
    predict(32'h100, 1'b0, 1'b0, "R6");  // counter {row,01} untouched
    train(32'h104, 1'b0);                // hist -> 10
    train(32'h104, 1'b0);                // hist -> 00
    predict(32'h100, 1'b1, 1'b0, "R6");  // counter {row,00} trained taken
    predict(32'h104, 1'b0, 1'b0, "R7");
  endtask

  // Chooser switch and index aliasing
  task automatic t_alias();
    do_reset();
    train(32'h40, 1'b1);
    predict(32'h40, 1'b0, 1'b0, "R5");   // agreement: chooser stays 01
    train(32'h40, 1'b1);
    predict(32'h40, 1'b1, 1'b1, "R3");   // chooser 10 picks address table
    predict(32'h41, 1'b1, 1'b1, "R7");   // alignment bits ignored
    predict(32'h1040, 1'b1, 1'b1, "R7"); // bits above index ignored
    predict(32'h44, 1'b0, 1'b0, "R7");   // neighbour entry untouched
  endtask

  // Combinational lookup within one cycle
  task automatic t_comb();
    @(negedge clk);
    pred_pc = 32'h40;
    #1 chk("R9", 1'b1, 1'b1);
    pred_pc = 32'h48;
    #1 chk("R9", 1'b0, 1'b0);
    pred_pc = 32'h40;
    #1 chk("R9", 1'b1, 1'b1);
  endtask

  // Idle update inputs change nothing
  task automatic t_idle();
    do_reset();
    @(negedge clk);
    upd_pc = 32'h300;
    upd_taken = 1'b1;
    upd_valid = 1'b0;
    repeat (4) @(negedge clk);
    predict(32'h300, 1'b0, 1'b0, "R8");
    train(32'h300, 1'b1);                // hist 00 -> 01 if idle left it alone
    train(32'h380, 1'b0);
    train(32'h380, 1'b0);                // hist back to 00
    predict(32'h300, 1'b1, 1'b0, "R8");
  endtask

  initial begin
    t_reset();
    t_saturate();
    t_history();
    t_alias();
    t_comb();
    t_idle();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule